// File: doc/BRIEF.md
# Load Result Former

This block sits between a data cache read port and the register write-back stage of an integer core. For each load it takes the 64-bit read beat, the low three address bits and a three-bit load-kind code. It picks the addressed byte, halfword or word lane out of the beat and widens that lane to the register width. Sign or zero extension follows the load kind. A doubleword load passes the whole beat through.

The register width is a parameter and may be 32 or 64. At 64 bits, a plain word load copies bit 31 into the upper half, and the unsigned word load fills the upper half with zeros. At 32 bits a word load needs no extension. At that width the doubleword and unsigned word kinds have no meaning, so the block raises an illegal flag and returns zero for them.

The result is registered. It appears, together with a valid bit, one clock after the input strobe.

Top module: `load_result_former`

## Requirements
- R1: Load kinds are coded as byte 0, halfword 1, word 2, doubleword 3, unsigned byte 4, unsigned halfword 5, unsigned word 6, reserved 7. At a 64-bit width, a word load takes bytes 4..7 of the beat when address bit 2 is 1 and bytes 0..3 when it is 0. It ignores address bits 1:0 and sign-extends the word from its bit 31.
- R2: At a 64-bit width an unsigned word load selects its word the same way as R1 and zero-extends it.
- R3: At a 64-bit width a doubleword load returns all 64 beat bits unchanged, whatever the address bits.
- R4: A byte load takes beat bits [8*a+7:8*a], where a is address bits 2:0. A halfword load takes bits [16*h+15:16*h], where h is address bits 2:1, and it ignores address bit 0. Kinds 0 and 1 sign-extend to the register width; kinds 4 and 5 zero-extend.
- R5: At a 32-bit width a word load returns the selected 32-bit word unchanged.
- R6: Kind 7 at any width, and kinds 3 and 6 at a 32-bit width, raise `illegal` together with the result and write a result of zero.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `illegal` is never high without `out_valid`.
- R8: Reset clears `out_valid`, `illegal` and `result`. With `in_valid` low, `result` keeps its last value, and changes on the kind, address or data inputs have no effect.
- R9: Register widths other than 32 or 64, and beat widths other than 64, are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load beat is present this cycle |
| load_kind | input | 3 | Load-kind code (see R1) |
| addr_lo | input | 3 | Low byte-address bits of the load |
| rdata | input | 64 | Read beat from memory, little-endian |
| out_valid | output | 1 | Result is new this cycle |
| result | output | REG_W | Extended load value |
| illegal | output | 1 | Load kind not allowed at this width |

## Verification
Back-to-back strobes make two of the block's functions share a cycle. The output register presents one load's result while the lane selector and extender form the next one. The vector table is therefore driven with `in_valid` held high on every cycle. Each result is judged one cycle after its own beat, while the following beat is already on the inputs. If the wrong beat were captured, or a leftover illegal flag carried over, a vector would miscompare. Examples are a legal load directly after a reserved kind, and an upper-lane word directly after a lower-lane one. A second instance at 32 bits is judged on the same inputs for the width-dependent cases.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

   typedef enum logic [2:0] {
      LK_B   = 3'd0,
      LK_H   = 3'd1,
      LK_W   = 3'd2,
      LK_D   = 3'd3,
      LK_BU  = 3'd4,
      LK_HU  = 3'd5,
      LK_WU  = 3'd6,
      LK_RSV = 3'd7
   } load_kind_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned HALF_W = 16;
   localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/lrf_lane_pick.sv
module lrf_lane_pick #(
   parameter int unsigned BUS_W     = 64,
   parameter int unsigned ADDR_LO_W = $clog2(BUS_W / 8)
) (
   input  logic [BUS_W-1:0]          beat,
   input  logic [ADDR_LO_W-1:0]      addr_lo,
   output logic [lrf_pkg::BYTE_W-1:0] byte_v,
   output logic [lrf_pkg::HALF_W-1:0] half_v,
   output logic [lrf_pkg::WORD_W-1:0] word_v
);
   localparam int unsigned N_BYTES = BUS_W / lrf_pkg::BYTE_W;
   localparam int unsigned N_HALFS = BUS_W / lrf_pkg::HALF_W;
   localparam int unsigned N_WORDS = BUS_W / lrf_pkg::WORD_W;

   logic [lrf_pkg::BYTE_W-1:0] byte_lane [N_BYTES];
   logic [lrf_pkg::HALF_W-1:0] half_lane [N_HALFS];
   logic [lrf_pkg::WORD_W-1:0] word_lane [N_WORDS];

   for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_byte
      assign byte_lane[gb] = beat[gb*lrf_pkg::BYTE_W +: lrf_pkg::BYTE_W];
   end
   for (genvar gh = 0; gh < N_HALFS; gh++) begin : g_half
      assign half_lane[gh] = beat[gh*lrf_pkg::HALF_W +: lrf_pkg::HALF_W];
   end
   for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_word
      assign word_lane[gw] = beat[gw*lrf_pkg::WORD_W +: lrf_pkg::WORD_W];
   end

   // byte uses all low bits, halfword drops bit 0, word drops bits 1:0
   assign byte_v = byte_lane[addr_lo];
   assign half_v = half_lane[addr_lo[ADDR_LO_W-1:1]];
   assign word_v = word_lane[addr_lo[ADDR_LO_W-1:2]];

endmodule

// File: rtl/lrf_extend.sv
module lrf_extend #(
   parameter int unsigned REG_W = 64,
   parameter int unsigned BUS_W = 64
) (
   input  lrf_pkg::load_kind_e        kind,
   input  logic [lrf_pkg::BYTE_W-1:0] byte_v,
   input  logic [lrf_pkg::HALF_W-1:0] half_v,
   input  logic [lrf_pkg::WORD_W-1:0] word_v,
   input  logic [BUS_W-1:0]           beat,
   output logic [REG_W-1:0]           value,
   output logic                       bad
);
   import lrf_pkg::*;

   localparam int unsigned B_PAD = REG_W - BYTE_W;
   localparam int unsigned H_PAD = REG_W - HALF_W;

   logic [REG_W-1:0] narrow_v;
   logic             narrow_hit;
   logic [REG_W-1:0] wide_v;
   logic             wide_bad;

   // widths common to both variants
   always_comb begin
      narrow_hit = 1'b1;
      unique case (kind)
         LK_B:    narrow_v = {{B_PAD{byte_v[BYTE_W-1]}}, byte_v};
         LK_BU:   narrow_v = {{B_PAD{1'b0}}, byte_v};
         LK_H:    narrow_v = {{H_PAD{half_v[HALF_W-1]}}, half_v};
         LK_HU:   narrow_v = {{H_PAD{1'b0}}, half_v};
         default: begin
            narrow_v   = '0;
            narrow_hit = 1'b0;
         end
      endcase
   end

   if (REG_W == 64) begin : g_w64
      always_comb begin
         wide_bad = 1'b0;
         unique case (kind)
            LK_W:    wide_v = {{(REG_W-WORD_W){word_v[WORD_W-1]}}, word_v};
            LK_WU:   wide_v = {{(REG_W-WORD_W){1'b0}}, word_v};
            LK_D:    wide_v = beat[REG_W-1:0];
            default: begin
               wide_v   = '0;
               wide_bad = 1'b1;
            end
         endcase
      end
   end else begin : g_w32
      logic [BUS_W-1:0] beat_unused;
      assign beat_unused = beat;
      always_comb begin
         wide_bad = 1'b0;
         unique case (kind)
            LK_W:    wide_v = word_v;
            default: begin
               wide_v   = '0;
               wide_bad = 1'b1;
            end
         endcase
      end
   end

   assign value = narrow_hit ? narrow_v : wide_v;
   assign bad   = !narrow_hit && wide_bad;

endmodule

// File: rtl/load_result_former.sv
module load_result_former #(
   parameter int unsigned REG_W     = 64,
   parameter int unsigned BUS_W     = 64,
   parameter int unsigned ADDR_LO_W = $clog2(BUS_W / 8)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           load_kind,
   input  logic [ADDR_LO_W-1:0] addr_lo,
   input  logic [BUS_W-1:0]     rdata,
   output logic                 out_valid,
   output logic [REG_W-1:0]     result,
   output logic                 illegal
);
   import lrf_pkg::*;

   // R9: elaboration-time parameter checks
   if (REG_W != 32 && REG_W != 64) begin : g_bad_reg_w
      $error("load_result_former: REG_W must be 32 or 64");
   end
   if (BUS_W != 64) begin : g_bad_bus_w
      $error("load_result_former: BUS_W must be 64");
   end

   load_kind_e           kind;
   logic [BYTE_W-1:0]    byte_v;
   logic [HALF_W-1:0]    half_v;
   logic [WORD_W-1:0]    word_v;
   logic [REG_W-1:0]     ext_v;
   logic                 ext_bad;

   assign kind = load_kind_e'(load_kind);

   lrf_lane_pick #(.BUS_W(BUS_W), .ADDR_LO_W(ADDR_LO_W)) lane_i (
      .beat    (rdata),
      .addr_lo (addr_lo),
      .byte_v  (byte_v),
      .half_v  (half_v),
      .word_v  (word_v)
   );

   lrf_extend #(.REG_W(REG_W), .BUS_W(BUS_W)) ext_i (
      .kind   (kind),
      .byte_v (byte_v),
      .half_v (half_v),
      .word_v (word_v),
      .beat   (rdata),
      .value  (ext_v),
      .bad    (ext_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         illegal   <= in_valid && ext_bad;
         if (in_valid) begin
            result <= ext_bad ? '0 : ext_v;
         end
      end
   end

   p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_illegal_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> out_valid);
   p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (result == '0));
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   p_reserved_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && load_kind == 3'd7) |=> illegal);

   if (REG_W == 64) begin : g_chk64
      p_dword_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && load_kind == 3'd3) |=> (result == $past(rdata)));
      p_word_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && load_kind == 3'd2) |=> (result[63:32] == {32{result[31]}}));
      p_uword_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && load_kind == 3'd6) |=> (result[63:32] == 32'h0));
   end else begin : g_chk32
      p_narrow_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (load_kind == 3'd3 || load_kind == 3'd6)) |=> illegal);
   end

endmodule

// File: tb/load_result_former_tb_top.sv
`timescale 1ns/1ps
module load_result_former_tb_top;

   typedef struct packed {
      logic [2:0]  kind;
      logic [2:0]  addr;
      logic [63:0] data;
      logic [63:0] exp;
      logic        bad;
   } vec_t;

   localparam logic [63:0] DA = 64'h8123_4567_F0E1_D2C3;
   localparam logic [63:0] DB = 64'h7FFF_FFFF_8000_0000;
   localparam int NV = 16;

   localparam vec_t VECS [NV] = '{
      '{3'd2, 3'd0, DA, 64'hFFFF_FFFF_F0E1_D2C3, 1'b0},  // R1 low word, negative
      '{3'd2, 3'd4, DA, 64'hFFFF_FFFF_8123_4567, 1'b0},  // R1 high word
      '{3'd2, 3'd5, DA, 64'hFFFF_FFFF_8123_4567, 1'b0},  // R1 addr[1:0] ignored
      '{3'd2, 3'd4, DB, 64'h0000_0000_7FFF_FFFF, 1'b0},  // R1 positive word
      '{3'd6, 3'd0, DA, 64'h0000_0000_F0E1_D2C3, 1'b0},  // R2
      '{3'd6, 3'd4, DA, 64'h0000_0000_8123_4567, 1'b0},  // R2
      '{3'd3, 3'd0, DA, DA,                      1'b0},  // R3
      '{3'd3, 3'd6, DB, DB,                      1'b0},  // R3 addr ignored
      '{3'd7, 3'd0, DA, 64'h0,                   1'b1},  // R6 reserved
      '{3'd0, 3'd0, DA, 64'hFFFF_FFFF_FFFF_FFC3, 1'b0},  // R4 legal after illegal
      '{3'd4, 3'd7, DA, 64'h0000_0000_0000_0081, 1'b0},  // R4
      '{3'd0, 3'd4, DA, 64'h0000_0000_0000_0067, 1'b0},  // R4
      '{3'd1, 3'd2, DA, 64'hFFFF_FFFF_FFFF_F0E1, 1'b0},  // R4
      '{3'd1, 3'd3, DA, 64'hFFFF_FFFF_FFFF_F0E1, 1'b0},  // R4 addr[0] ignored
      '{3'd5, 3'd6, DA, 64'h0000_0000_0000_8123, 1'b0},  // R4
      '{3'd1, 3'd4, DA, 64'h0000_0000_0000_4567, 1'b0}   // R4
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  load_kind = 3'd0;
   logic [2:0]  addr_lo = 3'd0;
   logic [63:0] rdata = 64'h0;
   logic        out_valid, illegal, out_valid32, illegal32;
   logic [63:0] result;
   logic [31:0] result32;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   load_result_former #(.REG_W(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .load_kind(load_kind),
      .addr_lo(addr_lo), .rdata(rdata),
      .out_valid(out_valid), .result(result), .illegal(illegal));

   load_result_former #(.REG_W(32)) dut32_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .load_kind(load_kind),
      .addr_lo(addr_lo), .rdata(rdata),
      .out_valid(out_valid32), .result(result32), .illegal(illegal32));

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd2:    return "R1";
         3'd6:    return "R2";
         3'd3:    return "R3";
         3'd7:    return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic gbad,
                      input logic gval, input logic [63:0] exp, input logic ebad,
                      input logic evld);
      checks++;
      if (got !== exp || gbad !== ebad || gval !== evld) begin
         fails++;
         $display("FAIL %s: got result=%h illegal=%b valid=%b exp result=%h illegal=%b valid=%b",
                  tag, got, gbad, gval, exp, ebad, evld);
      end
   endtask

   task automatic drive(input logic [2:0] k, input logic [2:0] a, input logic [63:0] d);
      in_valid  = 1'b1;
      load_kind = k;
      addr_lo   = a;
      rdata     = d;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R8 reset state, with live inputs during reset
      repeat (2) @(negedge clk);
      drive(3'd3, 3'd0, DA);
      @(negedge clk);
      chk("R8 reset", result, illegal, out_valid, 64'h0, 1'b0, 1'b0);
      chk("R8 reset w32", {32'h0, result32}, illegal32, out_valid32, 64'h0, 1'b0, 1'b0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // vector table, strobes back to back (R7 latency on every entry)
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].kind, VECS[i].addr, VECS[i].data);
         @(negedge clk);
         chk(tag_of(VECS[i].kind), result, illegal, out_valid,
             VECS[i].exp, VECS[i].bad, 1'b1);
      end

      // R8 / R7: idle cycles hold result, inputs ignored, valid and flag low
      in_valid  = 1'b0;
      load_kind = 3'd7;
      rdata     = DB;
      @(negedge clk);
      chk("R7 idle", result, illegal, out_valid, 64'h0000_0000_0000_4567, 1'b0, 1'b0);
      load_kind = 3'd3;
      addr_lo   = 3'd1;
      @(negedge clk);
      chk("R8 hold", result, illegal, out_valid, 64'h0000_0000_0000_4567, 1'b0, 1'b0);

      // R7: illegal followed by idle clears the flag
      drive(3'd7, 3'd0, DA);
      @(negedge clk);
      chk("R6 reserved", result, illegal, out_valid, 64'h0, 1'b1, 1'b1);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 flag clears", result, illegal, out_valid, 64'h0, 1'b0, 1'b0);

      // 32-bit width instance
      drive(3'd2, 3'd4, DA);
      @(negedge clk);
      chk("R5 w32 high word", {32'h0, result32}, illegal32, out_valid32,
          64'h8123_4567, 1'b0, 1'b1);
      drive(3'd2, 3'd0, DA);
      @(negedge clk);
      chk("R5 w32 low word", {32'h0, result32}, illegal32, out_valid32,
          64'hF0E1_D2C3, 1'b0, 1'b1);
      drive(3'd3, 3'd0, DA);
      @(negedge clk);
      chk("R6 w32 doubleword", {32'h0, result32}, illegal32, out_valid32,
          64'h0, 1'b1, 1'b1);
      drive(3'd0, 3'd0, DA);
      @(negedge clk);
      chk("R4 w32 byte", {32'h0, result32}, illegal32, out_valid32,
          64'hFFFF_FFC3, 1'b0, 1'b1);
      drive(3'd6, 3'd4, DA);
      @(negedge clk);
      chk("R6 w32 unsigned word", {32'h0, result32}, illegal32, out_valid32,
          64'h0, 1'b1, 1'b1);
      drive(3'd7, 3'd4, DA);
      @(negedge clk);
      chk("R6 w32 reserved", {32'h0, result32}, illegal32, out_valid32,
          64'h0, 1'b1, 1'b1);
      drive(3'd5, 3'd6, DA);
      @(negedge clk);
      chk("R4 w32 unsigned half", {32'h0, result32}, illegal32, out_valid32,
          64'h0000_8123, 1'b0, 1'b1);
      in_valid = 1'b0;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule